// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block is the serial register that surrounds a chip's pins for board-level test. Every pin gets one scan cell, sitting between the core logic and the pad: input pins, output pins and the pins of a bidirectional data bus. One extra cell in the chain holds the output enable of that bus. Each cell has a shift stage, which is part of the serial path from `tdi` to `tdo`, and an update latch behind it. The update latches are what drive the pins, or feed the core, while a test instruction is active.

An external test-access controller drives the block. It supplies the capture, shift and update strobes, the serial input and a test-logic reset, plus one decoded flag per instruction: external test, sample/preload and clamp. With no flag raised, the block is transparent and the chip runs normally.

The usual flow has four steps. Sample/preload captures the pins and shifts them out. Guard values are shifted in and updated. External test then drives the pads from the latches. Clamp holds the pads at the latched values while a different register uses the serial path.

Top module: `bscan_chain`

## Requirements
- R1: Capture, shift and update act only while the chain is selected, which means the external-test or sample/preload flag is high and clamp is low. Outside those times no shift stage and no update latch changes, whatever the strobes do.
- R2: On a selected capture strobe, each shift stage loads its own value. Input cells take the pad level. Output cells take the core output. Bus input cells take the bus pad level. The enable cell takes the core's bus enable. Bus output cells take the core's bus data.
- R3: On a selected shift strobe, every stage takes the value of its neighbour on the `tdi` side at the rising edge of `tck`. The first stage takes `tdi`.
- R4: `tdo` shows the stage nearest `tdo` and changes only on the falling edge of `tck`. A bit therefore appears on `tdo` half a cycle after the rising edge that moved it there.
- R5: On a selected update strobe, all update latches copy their shift stages in the same edge.
- R6: With neither external test nor clamp raised, `pad_out`, `pad_bus_out` and `pad_bus_oe` follow the core, and `core_in` and `core_bus_in` follow the pads.
- R7: Under external test, the output pads take the values of their update latches and ignore the core. `core_in` and `core_bus_in` take the values of the input cells' update latches and ignore the pads.
- R8: Under clamp, the output pads are driven from the update latches and the core inputs follow the pads. No shift stage or latch changes. At most one instruction flag is high at a time.
- R9: Under external test or clamp, `pad_bus_oe` equals the enable cell's latch. When that latch is 0, `pad_bus_out` is all zero, whatever the bus output latches hold.
- R10: With `IN_NEAR_TDI`=1 (the default), the chain order from `tdi` to `tdo` is fixed. It runs: the input cells (`pad_in` bit 0 first), the bus input cells (bit 0 first), the output cells (bit 0 first), the enable cell, then the bus output cells (bit 0 first, highest bit next to `tdo`). With `IN_NEAR_TDI`=0, the output cells come before the input group. The enable cell always sits directly before the bus output cells.
- R11: A low `rst_n` at a rising edge, or a high `tlr`, clears every shift stage and update latch to 0. A low `rst_n` at a falling edge clears `tdo` to 0.
- R12: When strobes coincide on a selected chain, capture takes precedence over shift, and shift takes precedence over update. Only the winning action takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tlr | input | 1 | Test-logic reset, clears the chain |
| cap_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| ir_extest | input | 1 | External test instruction active |
| ir_sample | input | 1 | Sample/preload instruction active |
| ir_clamp | input | 1 | Clamp instruction active |
| tdo | output | 1 | Serial data out, falling-edge timed |
| core_out | input | N_OUT | Core values for output pins |
| pad_out | output | N_OUT | Values to output pads |
| pad_in | input | N_IN | Levels from input pads |
| core_in | output | N_IN | Values to the core for input pins |
| core_bus_out | input | N_BUS | Core data for the bus |
| core_bus_oe | input | 1 | Core bus output enable |
| pad_bus_out | output | N_BUS | Data to bus pads |
| pad_bus_oe | output | 1 | Enable of bus pad drivers |
| pad_bus_in | input | N_BUS | Levels from bus pads |
| core_bus_in | output | N_BUS | Bus values delivered to the core |

## Verification
Two things can collide in one cycle. Strobes can arrive together, and the chain can change on the same rising edge whose effect `tdo` shows only at the following falling edge. The bench provokes the first by raising capture, shift and update in random combinations on a selected chain, and by mixing in unselected and clamped cycles. A behavioural vector model, compared every cycle, judges the result against the precedence rule. The bench judges the second by reading `tdo` one full cycle after each strobe, and by a directed readout whose bit order must match the stated cell order.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
// Package: shared control bundle for the scan-cell chain.
package bscan_pkg;

    // Decoded control for the chain and the pin multiplexers.
    typedef struct packed {
        logic sel;        // chain is the active serial path
        logic drive_pins; // pads take update-latch values
        logic feed_core;  // core inputs take update-latch values
        logic cap;        // gated capture
        logic shf;        // gated shift
        logic upd;        // gated update
    } bs_ctl_t;

endpackage

// File: rtl/bscan_ctrl.sv
`timescale 1ns/1ps
// Module: bscan_ctrl
// Turns the instruction flags and the strobes into gated cell controls.
// Assumes at most one instruction flag is high. Capture beats shift,
// and shift beats update, when strobes arrive together.
module bscan_ctrl
    import bscan_pkg::*;
(
    input  logic    tck,
    input  logic    rst_n,
    input  logic    ir_extest,
    input  logic    ir_sample,
    input  logic    ir_clamp,
    input  logic    cap_dr,
    input  logic    shift_dr,
    input  logic    update_dr,
    output bs_ctl_t ctl
);

    // Decode selection, pin drive and strobe precedence.
    always_comb begin
        ctl.sel        = (ir_extest | ir_sample) & ~ir_clamp;
        ctl.drive_pins = ir_extest | ir_clamp;
        ctl.feed_core  = ir_extest & ~ir_clamp;
        ctl.cap        = cap_dr & ctl.sel;
        ctl.shf        = shift_dr & ctl.sel & ~cap_dr;
        ctl.upd        = update_dr & ctl.sel & ~cap_dr & ~shift_dr;
    end

    // R8: the instruction decoder upstream keeps the flags exclusive.
    assert_flags_excl_R8: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({ir_extest, ir_sample, ir_clamp}))
        else $error("instruction flags not exclusive");

    // R12: gated strobes never overlap.
    assert_strobe_excl_R12: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({ctl.cap, ctl.shf, ctl.upd}))
        else $error("gated strobes overlap");

endmodule

// File: rtl/bscan_cell.sv
`timescale 1ns/1ps
// Module: bscan_cell
// One scan cell: a shift stage on the serial path plus an update latch.
// Assumes the strobes are already gated and mutually exclusive.
module bscan_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic clr,
    input  logic cap,
    input  logic shf,
    input  logic upd,
    input  logic si,
    input  logic pi,
    output logic so,
    output logic uq
);

    // Shift stage: parallel load on capture, serial load on shift.
    always_ff @(posedge tck) begin
        if (!rst_n || clr)
            so <= 1'b0;
        else if (cap)
            so <= pi;
        else if (shf)
            so <= si;
    end

    // Update latch: copies the shift stage on update.
    always_ff @(posedge tck) begin
        if (!rst_n || clr)
            uq <= 1'b0;
        else if (upd)
            uq <= so;
    end

    // R1: without capture, shift or clear the stage holds.
    assert_cell_hold_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (!cap && !shf && !clr) |=> $stable(so))
        else $error("shift stage moved without a strobe");

endmodule

// File: rtl/bscan_pin_mux.sv
`timescale 1ns/1ps
// Module: bscan_pin_mux
// Chooses between the functional path and the update latches for every pad
// and core input. A cleared bus-enable latch forces the bus data to zero.
module bscan_pin_mux #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int N_BUS = 4
) (
    input  logic             drive_pins,
    input  logic             feed_core,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] lat_out,
    output logic [N_OUT-1:0] pad_out,
    input  logic [N_IN-1:0]  pad_in,
    input  logic [N_IN-1:0]  lat_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_BUS-1:0] core_bus_out,
    input  logic             core_bus_oe,
    input  logic [N_BUS-1:0] lat_bus_out,
    input  logic             lat_bus_en,
    output logic [N_BUS-1:0] pad_bus_out,
    output logic             pad_bus_oe,
    input  logic [N_BUS-1:0] pad_bus_in,
    input  logic [N_BUS-1:0] lat_bus_in,
    output logic [N_BUS-1:0] core_bus_in
);

    // Output side: pads from the core or from the latches.
    always_comb begin
        pad_out    = drive_pins ? lat_out : core_out;
        pad_bus_oe = drive_pins ? lat_bus_en : core_bus_oe;
        if (!drive_pins)
            pad_bus_out = core_bus_out;
        else if (lat_bus_en)
            pad_bus_out = lat_bus_out;
        else
            pad_bus_out = '0;
    end

    // Input side: core from the pads or from the guard latches.
    always_comb begin
        core_in     = feed_core ? lat_in : pad_in;
        core_bus_in = feed_core ? lat_bus_in : pad_bus_in;
    end

endmodule

// File: rtl/bscan_tdo_stage.sv
`timescale 1ns/1ps
// Module: bscan_tdo_stage
// Re-times the last shift stage onto the falling edge of the test clock.
module bscan_tdo_stage (
    input  logic tck,
    input  logic rst_n,
    input  logic d,
    output logic tdo
);

    // Falling-edge output register.
    always_ff @(negedge tck) begin
        if (!rst_n)
            tdo <= 1'b0;
        else
            tdo <= d;
    end

endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
// Module: bscan_chain
// Boundary-scan chain around N_IN inputs, N_OUT outputs and an N_BUS-wide
// bidirectional bus, with one enable cell in front of the bus output cells.
// Assumes the strobes come from a test-access controller on tck.
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_IN        = 4,
    parameter int N_OUT       = 4,
    parameter int N_BUS       = 4,
    parameter bit IN_NEAR_TDI = 1'b1
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tlr,
    input  logic             cap_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    input  logic             ir_extest,
    input  logic             ir_sample,
    input  logic             ir_clamp,
    output logic             tdo,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pad_out,
    input  logic [N_IN-1:0]  pad_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_BUS-1:0] core_bus_out,
    input  logic             core_bus_oe,
    output logic [N_BUS-1:0] pad_bus_out,
    output logic             pad_bus_oe,
    input  logic [N_BUS-1:0] pad_bus_in,
    output logic [N_BUS-1:0] core_bus_in
);

    localparam int IN_W    = N_IN + N_BUS;
    localparam int LEN     = IN_W + N_OUT + 1 + N_BUS;
    localparam int OFS_IN  = IN_NEAR_TDI ? 0 : N_OUT;
    localparam int OFS_BIN = OFS_IN + N_IN;
    localparam int OFS_OUT = IN_NEAR_TDI ? IN_W : 0;
    localparam int OFS_EN  = IN_W + N_OUT;
    localparam int OFS_BO  = OFS_EN + 1;

    bs_ctl_t          ctl;
    logic [LEN-1:0]   pi_vec;
    logic [LEN-1:0]   si_vec;
    logic [LEN-1:0]   sh_vec;
    logic [LEN-1:0]   up_vec;

    // Strobe gating and instruction decode.
    bscan_ctrl u_ctrl (
        .tck       (tck),
        .rst_n     (rst_n),
        .ir_extest (ir_extest),
        .ir_sample (ir_sample),
        .ir_clamp  (ir_clamp),
        .cap_dr    (cap_dr),
        .shift_dr  (shift_dr),
        .update_dr (update_dr),
        .ctl       (ctl)
    );

    // Parallel capture sources placed at their chain positions.
    genvar g;
    generate
        for (g = 0; g < N_IN; g++) begin : g_pi_in
            assign pi_vec[OFS_IN + g] = pad_in[g];
        end
        for (g = 0; g < N_BUS; g++) begin : g_pi_bus
            assign pi_vec[OFS_BIN + g] = pad_bus_in[g];
            assign pi_vec[OFS_BO + g]  = core_bus_out[g];
        end
        for (g = 0; g < N_OUT; g++) begin : g_pi_out
            assign pi_vec[OFS_OUT + g] = core_out[g];
        end
    endgenerate
    assign pi_vec[OFS_EN] = core_bus_oe;

    // Serial neighbour: stage 0 takes tdi, stage k takes stage k-1.
    assign si_vec = {sh_vec[LEN-2:0], tdi};

    // One cell per chain position.
    generate
        for (g = 0; g < LEN; g++) begin : g_cell
            bscan_cell u_cell (
                .tck   (tck),
                .rst_n (rst_n),
                .clr   (tlr),
                .cap   (ctl.cap),
                .shf   (ctl.shf),
                .upd   (ctl.upd),
                .si    (si_vec[g]),
                .pi    (pi_vec[g]),
                .so    (sh_vec[g]),
                .uq    (up_vec[g])
            );
        end
    endgenerate

    // Pad and core multiplexing.
    bscan_pin_mux #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT),
        .N_BUS (N_BUS)
    ) u_mux (
        .drive_pins   (ctl.drive_pins),
        .feed_core    (ctl.feed_core),
        .core_out     (core_out),
        .lat_out      (up_vec[OFS_OUT +: N_OUT]),
        .pad_out      (pad_out),
        .pad_in       (pad_in),
        .lat_in       (up_vec[OFS_IN +: N_IN]),
        .core_in      (core_in),
        .core_bus_out (core_bus_out),
        .core_bus_oe  (core_bus_oe),
        .lat_bus_out  (up_vec[OFS_BO +: N_BUS]),
        .lat_bus_en   (up_vec[OFS_EN]),
        .pad_bus_out  (pad_bus_out),
        .pad_bus_oe   (pad_bus_oe),
        .pad_bus_in   (pad_bus_in),
        .lat_bus_in   (up_vec[OFS_BIN +: N_BUS]),
        .core_bus_in  (core_bus_in)
    );

    // Serial output on the falling edge.
    bscan_tdo_stage u_tdo (
        .tck   (tck),
        .rst_n (rst_n),
        .d     (sh_vec[LEN-1]),
        .tdo   (tdo)
    );

    logic chain_sel;
    assign chain_sel = (ir_extest || ir_sample) && !ir_clamp;

    // R1: an unselected chain keeps stages and latches.
    assert_idle_hold_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (!(ir_extest || ir_sample) && !tlr) |=> ($stable(sh_vec) && $stable(up_vec)))
        else $error("chain changed while unselected");

    // R2: capture loads the parallel sources.
    assert_capture_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_dr && chain_sel && !tlr) |=> (sh_vec == $past(pi_vec)))
        else $error("capture mismatch");

    // R3: shift moves one position toward tdo.
    assert_shift_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_dr && !cap_dr && chain_sel && !tlr)
        |=> (sh_vec == {$past(sh_vec[LEN-2:0]), $past(tdi)}))
        else $error("shift mismatch");

    // R5: update copies every stage into its latch.
    assert_update_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (update_dr && !cap_dr && !shift_dr && chain_sel && !tlr)
        |=> (up_vec == $past(sh_vec)))
        else $error("update mismatch");

    // R6: functional mode is transparent.
    assert_pass_R6: assert property (@(posedge tck) disable iff (!rst_n)
        (!ir_extest && !ir_clamp) |-> (pad_out == core_out && core_in == pad_in))
        else $error("functional path disturbed");

    // R8: clamp freezes the chain.
    assert_clamp_hold_R8: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_clamp && !tlr) |=> ($stable(sh_vec) && $stable(up_vec)))
        else $error("chain changed under clamp");

    // R9: a cleared enable latch quiets the bus under test.
    assert_bus_off_R9: assert property (@(posedge tck) disable iff (!rst_n)
        ((ir_extest || ir_clamp) && !up_vec[OFS_EN]) |-> (!pad_bus_oe && pad_bus_out == '0))
        else $error("bus driven with enable latch clear");

    // R11: test-logic reset clears the chain.
    assert_tlr_clear_R11: assert property (@(posedge tck) disable iff (!rst_n)
        tlr |=> (sh_vec == '0 && up_vec == '0))
        else $error("chain not cleared");

endmodule

// File: tb/bscan_chain_tb.sv
`timescale 1ns/1ps
// Bench: behavioural vector model of the chain, compared every cycle.
module bscan_chain_tb;

    localparam int NI = 4, NO = 4, NB = 4;
    localparam int L       = NI + NB + NO + 1 + NB;
    localparam int OFS_IN  = 0;
    localparam int OFS_BIN = NI;
    localparam int OFS_OUT = NI + NB;
    localparam int OFS_EN  = NI + NB + NO;
    localparam int OFS_BO  = OFS_EN + 1;

    logic clk = 1'b0;
    logic rst_n, tlr, cap, shf, upd, tdi_s, ext, smp, clp;
    logic tdo;
    logic [NO-1:0] core_out, pad_out;
    logic [NI-1:0] pad_in, core_in;
    logic [NB-1:0] core_bus_out, pad_bus_out, pad_bus_in, core_bus_in;
    logic core_bus_oe, pad_bus_oe;

    int total = 0, bad = 0;
    string phase = "R11";
    bit running = 0, done = 0, rnd = 0;
    logic rd;
    logic [L-1:0] msh, mup, expv, got, vv;
    logic mtdo;

    always #2 clk = ~clk; // 250 MHz

    bscan_chain u_dut (
        .tck(clk), .rst_n(rst_n), .tlr(tlr), .cap_dr(cap), .shift_dr(shf),
        .update_dr(upd), .tdi(tdi_s), .ir_extest(ext), .ir_sample(smp),
        .ir_clamp(clp), .tdo(tdo), .core_out(core_out), .pad_out(pad_out),
        .pad_in(pad_in), .core_in(core_in), .core_bus_out(core_bus_out),
        .core_bus_oe(core_bus_oe), .pad_bus_out(pad_bus_out),
        .pad_bus_oe(pad_bus_oe), .pad_bus_in(pad_bus_in),
        .core_bus_in(core_bus_in)
    );

    // Capture vector as R2 and R10 place it.
    function automatic logic [L-1:0] pvec();
        logic [L-1:0] v;
        for (int i = 0; i < NI; i++) v[OFS_IN + i]  = pad_in[i];
        for (int j = 0; j < NB; j++) v[OFS_BIN + j] = pad_bus_in[j];
        for (int i = 0; i < NO; i++) v[OFS_OUT + i] = core_out[i];
        v[OFS_EN] = core_bus_oe;
        for (int j = 0; j < NB; j++) v[OFS_BO + j]  = core_bus_out[j];
        return v;
    endfunction

    // Reference model of stages and latches.
    always @(posedge clk) begin
        if (!rst_n || tlr) begin
            msh <= '0;
            mup <= '0;
        end else if ((ext || smp) && !clp) begin
            if (cap)      msh <= pvec();
            else if (shf) msh <= {msh[L-2:0], tdi_s};
            else if (upd) mup <= msh;
        end
    end

    always @(negedge clk) mtdo <= !rst_n ? 1'b0 : msh[L-1];

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", phase, what, act, exp);
        end
    endtask

    // Per-cycle comparison of every output against the model.
    always @(posedge clk) begin
        #1;
        if (running && !done) begin
            logic drv;
            logic [NO-1:0] e_out;
            logic [NI-1:0] e_in;
            logic [NB-1:0] e_bo, e_bi;
            drv = ext || clp;
            for (int i = 0; i < NO; i++) e_out[i] = drv ? mup[OFS_OUT + i] : core_out[i];
            for (int i = 0; i < NI; i++) e_in[i]  = ext ? mup[OFS_IN + i] : pad_in[i];
            for (int j = 0; j < NB; j++) begin
                e_bo[j] = drv ? (mup[OFS_EN] & mup[OFS_BO + j]) : core_bus_out[j];
                e_bi[j] = ext ? mup[OFS_BIN + j] : pad_bus_in[j];
            end
            chk("tdo (R4)", 32'(tdo), 32'(mtdo));
            chk("pad_out", 32'(pad_out), 32'(e_out));
            chk("core_in", 32'(core_in), 32'(e_in));
            chk("pad_bus_oe (R9)", 32'(pad_bus_oe), 32'(drv ? mup[OFS_EN] : core_bus_oe));
            chk("pad_bus_out (R9)", 32'(pad_bus_out), 32'(e_bo));
            chk("core_bus_in", 32'(core_bus_in), 32'(e_bi));
        end
    end

    task automatic randpins();
        core_out = NO'($urandom); pad_in = NI'($urandom);
        core_bus_out = NB'($urandom); pad_bus_in = NB'($urandom);
        core_bus_oe = 1'($urandom);
    endtask

    // One cycle; returns tdo as it stood before this cycle's edge acted.
    task automatic step(input logic c, input logic s, input logic u, input logic d, output logic r);
        #2;
        cap = c; shf = s; upd = u; tdi_s = d;
        if (rnd) randpins();
        @(posedge clk); #1;
        r = tdo;
    endtask

    task automatic mode(input logic e, input logic s, input logic c);
        #2;
        ext = e; smp = s; clp = c; cap = 0; shf = 0; upd = 0;
        @(posedge clk); #1;
    endtask

    task automatic load(input logic [L-1:0] v);
        for (int k = 0; k < L; k++) step(0, 1, 0, v[L-1-k], rd);
        step(0, 0, 1, 0, rd);
    endtask

    task automatic rstrobes(input int n);
        for (int k = 0; k < n; k++)
            step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), rd);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R4 watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; tlr = 0; cap = 0; shf = 0; upd = 0; tdi_s = 0;
        ext = 0; smp = 0; clp = 0;
        core_out = '0; pad_in = '0; core_bus_out = '0; pad_bus_in = '0; core_bus_oe = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("tdo after reset R11", 32'(tdo), 0);
        #2 rst_n = 1;
        @(posedge clk); #1;
        running = 1;

        // R11: latches start cleared, visible under external test.
        mode(1, 0, 0);
        core_out = '1;
        step(0, 0, 0, 0, rd);
        chk("pad_out cleared R11", 32'(pad_out), 0);
        chk("bus oe cleared R11", 32'(pad_bus_oe), 0);

        phase = "R6"; mode(0, 0, 0); rnd = 1;
        repeat (12) step(0, 0, 0, 0, rd);

        // R2 then R10: capture, then read the chain back in order.
        phase = "R2"; mode(0, 1, 0);
        step(1, 0, 0, 0, rd);
        rnd = 0;
        expv = pvec();
        vv = L'($urandom);
        phase = "R10";
        for (int k = 0; k < L; k++) begin
            step(0, 1, 0, vv[L-1-k], rd);
            got[L-1-k] = rd;
        end
        chk("serial readout order R10", 32'(got), 32'(expv));

        phase = "R5"; step(0, 0, 1, 0, rd);
        phase = "R7"; mode(1, 0, 0); rnd = 1;
        repeat (4) step(0, 0, 0, 0, rd);
        chk("pad_out from latches R7", 32'(pad_out), 32'(vv[OFS_OUT +: NO]));
        chk("core_in from guards R7", 32'(core_in), 32'(vv[OFS_IN +: NI]));

        phase = "R3";
        for (int k = 0; k < 20; k++) step(0, 1, 0, 1'($urandom), rd);
        step(0, 0, 1, 0, rd);
        repeat (3) step(0, 0, 0, 0, rd);

        phase = "R8"; mode(0, 0, 1); rstrobes(20);

        // R9: enable latch cleared, then set.
        phase = "R9"; rnd = 0; mode(0, 1, 0);
        vv = L'($urandom); vv[OFS_EN] = 1'b0; vv[OFS_BO +: NB] = '1;
        load(vv);
        core_bus_oe = 1; core_bus_out = '1;
        mode(1, 0, 0);
        chk("bus tri-stated R9", 32'(pad_bus_oe), 0);
        chk("bus data ignored R9", 32'(pad_bus_out), 0);
        mode(0, 1, 0);
        vv[OFS_EN] = 1'b1; vv[OFS_BO +: NB] = NB'(4'hA);
        load(vv);
        mode(0, 0, 1);
        chk("bus enabled R9", 32'(pad_bus_oe), 1);
        chk("bus data R9", 32'(pad_bus_out), 32'(NB'(4'hA)));

        phase = "R1"; rnd = 1; mode(0, 0, 0); rstrobes(20);
        phase = "R12"; mode(0, 1, 0); rstrobes(40);
        mode(1, 0, 0); rstrobes(40);

        // R4 and R11: fully random traffic with occasional test-logic reset.
        phase = "R4";
        for (int k = 0; k < 300; k++) begin
            int f;
            #2;
            f = int'($urandom_range(0, 3));
            ext = (f == 1); smp = (f == 2); clp = (f == 3);
            cap = 1'($urandom); shf = 1'($urandom); upd = 1'($urandom);
            tdi_s = 1'($urandom);
            tlr = ($urandom_range(0, 31) == 0);
            randpins();
            @(posedge clk); #1;
        end
        #2 tlr = 0;
        @(posedge clk); #1;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule